// File: doc/BRIEF.md
# Constant On-Time Switching Sequencer

This block sequences the two gate enables of a buck converter that regulates with a constant on-time scheme. There is no switching clock. When the feedback comparator reports that the output has dropped under its reference, the block fires a high-side pulse whose length in clock cycles follows the ratio of the output-voltage code to the input-voltage code. A minimum off interval follows every pulse. This keeps the switching frequency roughly fixed across input and output settings.

The low side conducts whenever the high side is idle. Two current flags taken from the low-side switch gate the next pulse. An over-limit valley flag holds the high side off until the current falls. A negative over-current flag turns the low side off and starts a retry loop: a long idle wait, then a short re-sense pulse, repeated for as long as the flag stays set. A one-cycle dead gap separates every hand-over between the two switches. After enable, the sequence always opens with the low side so that the bootstrap supply is charged.

Top module: `cot_sequencer`

## Requirements
- R1: While `rst_n` is low, or one clock after `en` is seen low, both `hs_en` and `ls_en` are low.
- R2: After `en` rises, `ls_en` goes high one clock later while `hs_en` stays low. With `fb_low` held high, the low side stays on for exactly MIN_OFF+1 cycles, then one dead cycle follows, and only then does the first high-side pulse start.
- R3: Each high-side pulse lasts `floor(K*vout_code/vin_code)` cycles, clamped to a minimum of 1 cycle. A `vin_code` of 0 is treated as 1. The codes are sampled in the dead cycle just before the pulse.
- R4: When `vout_code` is greater than HI_VOUT_CODE, the on-time becomes `floor(K*vout_code*85/(vin_code*100))`, with the same clamp. At a code equal to HI_VOUT_CODE, no scaling applies.
- R5: With `fb_low` held high, exactly MIN_OFF+2 cycles pass with `hs_en` low between two high-side pulses. `ls_en` is high for exactly MIN_OFF of those cycles.
- R6: A high-side pulse starts only if `fb_low` was high two clocks before `hs_en` rises. While `fb_low` stays low, `hs_en` stays low and `ls_en` stays high.
- R7: While `valley_over` is high, no high-side pulse starts. Once it falls, with the other conditions met, `hs_en` rises two clocks later.
- R8: If `neg_over` is high while the low side is in normal conduction, `ls_en` falls at the next clock. It then stays low for NEG_WAIT cycles and goes high for a NEG_ON-cycle re-sense pulse. This repeats while `neg_over` is high at the end of the re-sense pulse; otherwise normal low-side conduction resumes.
- R9: `hs_en` and `ls_en` are never high together, and each hand-over between them has at least one cycle with both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces both gates off and restarts the sequence |
| fb_low | input | 1 | Feedback is below the reference |
| vin_code | input | W | Input-voltage code |
| vout_code | input | W | Output-voltage code |
| valley_over | input | 1 | Low-side current is above the valley limit |
| neg_over | input | 1 | Low-side node is above the negative over-current threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The properties assume that the inputs are synchronous to `clk`, and that they change only between edges. They also assume that a two-cycle history of `fb_low` and `valley_over` is meaningful when a pulse begins. Treating the current flags as level-sensitive needs no assumption about how long they stay high. The bench drives every input on the falling edge and holds the voltage codes steady from the end of one high-side pulse through the next. The re-sense retry is exercised by holding `neg_over` high across one full wait/probe round and releasing it in the middle of a wait.

// File: rtl/cot_sequencer.sv
module cot_sequencer #(
  parameter int W            = 8,
  parameter int K            = 64,
  parameter int MIN_OFF      = 50,
  parameter int BOOT_CYC     = 8,
  parameter int NEG_WAIT     = 312,
  parameter int NEG_ON       = 37,
  parameter int HI_VOUT_CODE = 165
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fb_low,
  input  logic [W-1:0] vin_code,
  input  logic [W-1:0] vout_code,
  input  logic         valley_over,
  input  logic         neg_over,
  output logic         hs_en,
  output logic         ls_en
);
  localparam int PW   = W + $clog2(K) + 9;
  localparam int TNED = ((K << W) > NEG_WAIT) ? (K << W) : NEG_WAIT;
  localparam int TW   = $clog2(TNED + 1) + 1;
  localparam int OW   = $clog2(MIN_OFF + 1) + 1;
  localparam logic [TW-1:0] TMAX = '1;

  typedef enum logic [2:0] {S_IDLE, S_BOOT, S_LS, S_DHL, S_HS, S_DLH, S_NWAIT, S_PROBE} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [OW-1:0] off_cnt;
  logic [PW-1:0] prod, den, quo;
  logic [TW-1:0] ton;
  logic          hi_v, off_done, go;

  assign hi_v = vout_code > W'(HI_VOUT_CODE);
  assign prod = PW'(K) * PW'(vout_code) * (hi_v ? PW'(85) : PW'(100));
  assign den  = ((vin_code == '0) ? PW'(1) : PW'(vin_code)) * PW'(100);
  assign quo  = prod / den;
  assign ton  = (quo == '0) ? TW'(1) : (quo > PW'(TMAX)) ? TMAX : quo[TW-1:0];

  assign off_done = off_cnt == OW'(MIN_OFF);
  assign go       = off_done && fb_low && !valley_over;

  assign hs_en = st == S_HS;
  assign ls_en = (st == S_BOOT) || (st == S_LS) || (st == S_PROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_cnt <= '0;
    else if (st == S_IDLE || st == S_HS) off_cnt <= '0;
    else if (!off_done) off_cnt <= off_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      tmr <= '0;
    end else if (!en) begin
      st  <= S_IDLE;
      tmr <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st  <= S_BOOT;
          tmr <= TW'(BOOT_CYC - 1);
        end
        S_BOOT:
          if (tmr == '0) st <= S_LS;
          else tmr <= tmr - 1'b1;
        S_LS:
          if (neg_over) begin
            st  <= S_NWAIT;
            tmr <= TW'(NEG_WAIT - 1);
          end else if (go) st <= S_DHL;
        S_DHL: begin
          st  <= S_HS;
          tmr <= ton - 1'b1;
        end
        S_HS:
          if (tmr == '0) st <= S_DLH;
          else tmr <= tmr - 1'b1;
        S_DLH: st <= S_LS;
        S_NWAIT:
          if (tmr == '0) begin
            st  <= S_PROBE;
            tmr <= TW'(NEG_ON - 1);
          end else tmr <= tmr - 1'b1;
        S_PROBE:
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (neg_over) begin
            st  <= S_NWAIT;
            tmr <= TW'(NEG_WAIT - 1);
          end else st <= S_LS;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cot_sequencer_chk.sv
module cot_sequencer_chk #(
  parameter int MIN_OFF = 50
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic fb_low,
  input logic valley_over,
  input logic hs_en,
  input logic ls_en
);
  localparam int GW = $clog2(MIN_OFF + 1) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (hs_en) gap <= '0;
    else if (gap != GW'(MIN_OFF)) gap <= gap + 1'b1;
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(hs_en && ls_en));
  p_dead_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_en) |-> !$past(ls_en));
  p_dead_back_r9: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_en) |-> !$past(hs_en));
  p_off_r1: assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!hs_en && !ls_en));
  p_fb_gate_r6: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_en) |-> $past(fb_low, 2));
  p_valley_r7: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_en) |-> !$past(valley_over, 2));
  p_min_off_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_en) |-> (gap >= GW'(MIN_OFF)));
endmodule

bind cot_sequencer cot_sequencer_chk #(.MIN_OFF(MIN_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fb_low(fb_low),
  .valley_over(valley_over), .hs_en(hs_en), .ls_en(ls_en)
);

// File: tb/test_cot_sequencer.sv
module test_cot_sequencer;
  localparam int MIN_OFF = 50;
  localparam int NEG_WAIT = 312;
  localparam int NEG_ON = 37;
  localparam int NV = 8;
  localparam int VEC [NV][3] = '{
    '{200,  50,  16}, '{100, 100,  64}, '{250,  25,   6}, '{200, 200,  54},
    '{255,   1,   1}, '{  0,  10, 640}, '{180, 166,  50}, '{180, 165,  58}
  };

  logic clk = 0, rst_n = 0, en = 0, fb_low = 0, valley_over = 0, neg_over = 0;
  logic [7:0] vin_code = 8'd200, vout_code = 8'd50;
  logic hs_en, ls_en;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cot_sequencer i_cot_sequencer (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_low(fb_low), .vin_code(vin_code),
    .vout_code(vout_code), .valley_over(valley_over), .neg_over(neg_over),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic wait_hs_fall();
    int n = 0;
    while (!hs_en && n < 5000) begin @(negedge clk); n++; end
    while (hs_en && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int gap, output int lsn, output int hi);
    gap = 0; lsn = 0; hi = 0;
    while (!hs_en && gap < 5000) begin
      gap++; if (ls_en) lsn++;
      if (hs_en && ls_en) chk("R9 overlap", 1, 0);
      @(negedge clk);
    end
    while (hs_en && hi < 5000) begin
      hi++;
      if (ls_en) chk("R9 overlap", 1, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int g, l, h, cnt;
    repeat (3) @(negedge clk);
    chk("R1 reset hs", hs_en, 0);
    chk("R1 reset ls", ls_en, 0);
    rst_n = 1; fb_low = 1;
    @(negedge clk);
    en = 1;
    @(negedge clk);
    chk("R2 first ls", ls_en, 1);
    chk("R2 first hs", hs_en, 0);
    wait_hs_fall();

    for (int i = 0; i < NV; i++) begin
      vin_code = 8'(VEC[i][0]); vout_code = 8'(VEC[i][1]);
      measure(g, l, h);
      chk($sformatf("R3/R4 ton vec%0d", i), h, VEC[i][2]);
      chk($sformatf("R5 gap vec%0d", i), g, MIN_OFF + 2);
      chk($sformatf("R5 ls in gap vec%0d", i), l, MIN_OFF);
    end

    vin_code = 8'd200; vout_code = 8'd50;
    fb_low = 0;
    repeat (60) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      if (hs_en || !ls_en) cnt++;
      @(negedge clk);
    end
    chk("R6 fb high holds off hs", cnt, 0);

    neg_over = 1;
    @(negedge clk);
    chk("R8 ls off next clock", ls_en, 0);
    l = 1; @(negedge clk);
    while (!ls_en && l < 2000) begin l++; @(negedge clk); end
    chk("R8 wait length", l, NEG_WAIT);
    h = 0;
    while (ls_en && h < 2000) begin h++; @(negedge clk); end
    chk("R8 probe length", h, NEG_ON);
    chk("R8 retry wait again", ls_en, 0);
    repeat (10) @(negedge clk);
    neg_over = 0;
    repeat (NEG_WAIT + NEG_ON + 20) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      if (!ls_en) cnt++;
      @(negedge clk);
    end
    chk("R8 resume ls", cnt, 0);

    valley_over = 1; fb_low = 1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      if (hs_en) cnt++;
      @(negedge clk);
    end
    chk("R7 valley blocks hs", cnt, 0);
    valley_over = 0;
    @(negedge clk);
    chk("R9 dead cycle ls", ls_en, 0);
    chk("R7 hs not yet", hs_en, 0);
    @(negedge clk);
    chk("R7 hs two clocks later", hs_en, 1);

    en = 0;
    @(negedge clk);
    chk("R1 disable hs", hs_en, 0);
    chk("R1 disable ls", ls_en, 0);
    repeat (5) @(negedge clk);
    en = 1;
    @(negedge clk);
    chk("R2 restart hs low", hs_en, 0);
    l = 0;
    while (ls_en && !hs_en && l < 2000) begin l++; @(negedge clk); end
    chk("R2 boot ls length", l, MIN_OFF + 1);
    chk("R2 dead before hs", hs_en, 0);
    @(negedge clk);
    chk("R2 first hs", hs_en, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule